// File: doc/BRIEF.md
# Banked Work RAM Controller

This block serves a byte-wide work memory on a 16-bit CPU address bus. The memory is split into eight equal banks, and the CPU sees it through two windows. The lower window always shows bank 0. The upper window shows whichever bank a small select register currently names. The CPU writes and reads that select register at its own I/O address. The block holds the storage array itself. For every request it reports at once whether the address belongs to it, and it returns read data one cycle later.

The window base addresses, the select-register address and the window size are parameters. The full-size build sets `WIN_AW = 12`: the windows then cover 0xC000–0xCFFF and 0xD000–0xDFFF, and the array holds 32 KiB. The default build keeps the same map but sets `WIN_AW = 8`, so each window covers the first 256 bytes of its 4 KiB slot. The storage is then 8 × 256 bytes.

Top module: `wram_bank_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the bank select is 0, and bus_rdata reads 0x00 until the first read completes.
- R2: An access to LOW_BASE + n, with n < 2^WIN_AW, hits in the same cycle. It reaches physical byte n (bank 0), whatever the bank select holds.
- R3: An access to HIGH_BASE + n, with n < 2^WIN_AW, hits in the same cycle. It reaches physical byte bank × 2^WIN_AW + n.
- R4: A write to BANK_ADDR (0xFF70) hits and stores only bus_wdata[2:0]. A read of BANK_ADDR returns the stored value in bits [2:0], with bits [7:3] at 0.
- R5: A bank-select write takes effect for an upper-window access issued in the very next cycle. Without a write the select holds its value.
- R6: Read data for a request in cycle t appears on bus_rdata after the clock edge that ends cycle t. It holds until the next read request completes, and write or idle cycles leave it unchanged.
- R7: An access to any other address does not hit and leaves the array and the bank select unchanged. A read of such an address returns 0x00.
- R8: With bank select 0, the upper window and the lower window reach the same bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | CPU byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read request |
| bus_hit | output | 1 | Address falls in a window or on the select register (combinational) |

## Verification
A wrong bank select shows up in the very next upper-window read, which returns another bank's pattern byte. The bench fills every bank with a pattern computed from its bank number and offset. It then reads every byte back, so a stuck or mis-shifted bank bit, or a bad offset bit, shows as a miscompare within one cycle of the faulty access. A decoder that lets a stray address write to the array is caught later, when the overwritten byte is read back during the miss checks.

// File: rtl/wram_pkg.sv
// Shared types for the banked work RAM controller.
// Assumes: the region code is used only between the decoder and the top.
package wram_pkg;
    typedef enum logic [1:0] {
        RGN_NONE    = 2'd0,
        RGN_LOW     = 2'd1,
        RGN_HIGH    = 2'd2,
        RGN_BANKREG = 2'd3
    } wram_rgn_e;
endpackage

// File: rtl/wram_decode.sv
// Address decoder: classifies a bus address into the lower window, the upper
// window, the bank-select register or nothing, and gives the window offset.
// Assumes: WIN_AW < ADDR_W, and the windows do not overlap each other or BANK_ADDR.
module wram_decode
    import wram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_AW = 8,
    parameter logic [ADDR_W-1:0] LOW_BASE  = 16'hC000,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 16'hD000,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 16'hFF70
) (
    input  logic [ADDR_W-1:0] addr,
    output wram_rgn_e         rgn,
    output logic [WIN_AW-1:0] offs
);
    logic [ADDR_W-1:0] low_d;
    logic [ADDR_W-1:0] high_d;
    logic              low_in;
    logic              high_in;

    // Distance from each window base; an address is inside when the upper bits are zero.
    always_comb begin
        low_d   = addr - LOW_BASE;
        high_d  = addr - HIGH_BASE;
        low_in  = (low_d[ADDR_W-1:WIN_AW] == '0);
        high_in = (high_d[ADDR_W-1:WIN_AW] == '0);
    end

    // Pick the region and the offset inside it.
    always_comb begin
        rgn  = RGN_NONE;
        offs = '0;
        if (low_in) begin
            rgn  = RGN_LOW;
            offs = low_d[WIN_AW-1:0];
        end else if (high_in) begin
            rgn  = RGN_HIGH;
            offs = high_d[WIN_AW-1:0];
        end else if (addr == BANK_ADDR) begin
            rgn  = RGN_BANKREG;
        end
    end
endmodule

// File: rtl/wram_bank_reg.sv
// Bank-select register: holds the bank number for the upper window.
// Assumes: wr_val already carries only the stored bits.
module wram_bank_reg #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_val,
    output logic [BANK_W-1:0] bank
);
    // Load on a write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (wr_en)
            bank <= wr_val;
    end

    AST_BANK_RESET: assert property (@(posedge clk) !rst_n |=> bank == '0); // R1
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank)); // R5
endmodule

// File: rtl/wram_array.sv
// Single-port byte storage with a registered read port.
// Assumes: no reset of contents; rdata_q changes only on a read strobe.
module wram_array #(
    parameter int DATA_W = 8,
    parameter int AW     = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write the addressed byte, or register the addressed byte on a read.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        if (re)
            rdata_q <= mem[addr];
    end
endmodule

// File: rtl/wram_bank_ctrl.sv
// Banked work RAM controller top: a fixed lower window on bank 0, a switchable
// upper window on the bank held in a select register at BANK_ADDR.
// Assumes: DATA_W >= BANK_W; single-cycle bus, one access per cycle.
module wram_bank_ctrl
    import wram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 3,
    parameter int WIN_AW = 8,
    parameter logic [ADDR_W-1:0] LOW_BASE  = 16'hC000,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 16'hD000,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 16'hFF70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit
);
    localparam int PHYS_AW = BANK_W + WIN_AW;

    wram_rgn_e           rgn;
    wram_rgn_e           rd_kind;
    logic [WIN_AW-1:0]   offs;
    logic [BANK_W-1:0]   bank;
    logic [BANK_W-1:0]   bank_snap;
    logic [PHYS_AW-1:0]  phys;
    logic                in_win;
    logic                mem_we;
    logic                mem_re;
    logic                bank_wr;
    logic [DATA_W-1:0]   mem_q;

    wram_decode #(
        .ADDR_W(ADDR_W), .WIN_AW(WIN_AW),
        .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE), .BANK_ADDR(BANK_ADDR)
    ) u_dec (
        .addr(bus_addr), .rgn(rgn), .offs(offs)
    );

    wram_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bank_wr),
        .wr_val(bus_wdata[BANK_W-1:0]), .bank(bank)
    );

    wram_array #(.DATA_W(DATA_W), .AW(PHYS_AW)) u_mem (
        .clk(clk), .we(mem_we), .re(mem_re), .addr(phys),
        .wdata(bus_wdata), .rdata_q(mem_q)
    );

    // Strobes and physical address: the upper window is offset by the bank number.
    always_comb begin
        in_win  = (rgn == RGN_LOW) || (rgn == RGN_HIGH);
        mem_we  = bus_req && bus_we && in_win;
        mem_re  = bus_req && !bus_we && in_win;
        bank_wr = bus_req && bus_we && (rgn == RGN_BANKREG);
        bus_hit = bus_req && (rgn != RGN_NONE);
        phys    = (rgn == RGN_HIGH) ? {bank, offs} : {{BANK_W{1'b0}}, offs};
    end

    // Remember what the last read targeted so the data mux picks the right source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_kind   <= RGN_NONE;
            bank_snap <= '0;
        end else if (bus_req && !bus_we) begin
            rd_kind   <= rgn;
            bank_snap <= bank;
        end
    end

    // Return data: array byte, zero-extended bank number, or zero on a miss.
    always_comb begin
        case (rd_kind)
            RGN_LOW, RGN_HIGH: bus_rdata = mem_q;
            RGN_BANKREG:       bus_rdata = DATA_W'(bank_snap);
            default:           bus_rdata = '0;
        endcase
    end

    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_hit) |-> !mem_we); // R7
    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !bus_hit) |=> bus_rdata == '0); // R7
    AST_BANK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && rgn == RGN_BANKREG) |=> bus_rdata == DATA_W'($past(bank))); // R4
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && rgn == RGN_BANKREG) |=> bank == $past(bus_wdata[BANK_W-1:0])); // R5
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> $stable(bus_rdata)); // R6
endmodule

// File: tb/sim_wram_bank_ctrl.sv
`timescale 1ns/1ps
module sim_wram_bank_ctrl;
    localparam int WIN = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_hit;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wram_bank_ctrl #(.WIN_AW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_hit(bus_hit)
    );

    function automatic logic [7:0] pat_hi(input int b, input int off);
        return 8'((b * 37 + off * 5 + 3) & 255);
    endfunction

    function automatic logic [7:0] pat_lo(input int off);
        return 8'((off * 11) ^ 8'hA5);
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // One bus cycle starting at a falling edge; hit checked in-cycle, read data next falling edge.
    task automatic acc(input logic we, input logic [15:0] a, input logic [7:0] d,
                       input logic exp_hit, input logic chk_rd, input logic [7:0] exp,
                       input string req);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        chk(req, "hit", {7'd0, bus_hit}, {7'd0, exp_hit});
        @(negedge clk);
        if (chk_rd) chk(req, "rdata", bus_rdata, exp);
        bus_req = 1'b0;
    endtask

    task automatic idle();
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=01 expected=00");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rdata after reset", bus_rdata, 8'h00);
        acc(1'b0, 16'hFF70, 8'h00, 1'b1, 1'b1, 8'h00, "R1");

        // R4: only three bits stored, upper bits read as zero
        acc(1'b1, 16'hFF70, 8'hFF, 1'b1, 1'b0, 8'h00, "R4");
        acc(1'b0, 16'hFF70, 8'h00, 1'b1, 1'b1, 8'h07, "R4");
        acc(1'b1, 16'hFF70, 8'h0D, 1'b1, 1'b0, 8'h00, "R4");
        acc(1'b0, 16'hFF70, 8'h00, 1'b1, 1'b1, 8'h05, "R4");

        // R3: fill every bank through the upper window
        for (int b = 0; b < 8; b++) begin
            acc(1'b1, 16'hFF70, 8'(b), 1'b1, 1'b0, 8'h00, "R5");
            for (int o = 0; o < WIN; o++)
                acc(1'b1, 16'(16'hD000 + o), pat_hi(b, o), 1'b1, 1'b0, 8'h00, "R3");
        end
        // R2: fill the lower window (overwrites bank 0)
        for (int o = 0; o < WIN; o++)
            acc(1'b1, 16'(16'hC000 + o), pat_lo(o), 1'b1, 1'b0, 8'h00, "R2");

        // R3 / R8: read every bank back
        for (int b = 0; b < 8; b++) begin
            acc(1'b1, 16'hFF70, 8'(b), 1'b1, 1'b0, 8'h00, "R5");
            for (int o = 0; o < WIN; o++)
                acc(1'b0, 16'(16'hD000 + o), 8'h00, 1'b1, 1'b1,
                    (b == 0) ? pat_lo(o) : pat_hi(b, o), (b == 0) ? "R8" : "R3");
        end
        // R2: lower window ignores bank select (now 7)
        for (int o = 0; o < WIN; o++)
            acc(1'b0, 16'(16'hC000 + o), 8'h00, 1'b1, 1'b1, pat_lo(o), "R2");

        // R5: bank write used by the very next access
        acc(1'b1, 16'hFF70, 8'h03, 1'b1, 1'b0, 8'h00, "R5");
        acc(1'b0, 16'hD010, 8'h00, 1'b1, 1'b1, pat_hi(3, 16'h10), "R5");
        acc(1'b1, 16'hFF70, 8'h05, 1'b1, 1'b0, 8'h00, "R5");
        acc(1'b1, 16'hD011, 8'h5A, 1'b1, 1'b0, 8'h00, "R5");
        acc(1'b0, 16'hD011, 8'h00, 1'b1, 1'b1, 8'h5A, "R5");
        acc(1'b1, 16'hFF70, 8'h03, 1'b1, 1'b0, 8'h00, "R5");
        acc(1'b0, 16'hD011, 8'h00, 1'b1, 1'b1, pat_hi(3, 16'h11), "R5");

        // R6: read data holds through idle and write cycles
        acc(1'b0, 16'hC005, 8'h00, 1'b1, 1'b1, pat_lo(5), "R6");
        idle();
        chk("R6", "rdata hold idle", bus_rdata, pat_lo(5));
        idle();
        chk("R6", "rdata hold idle", bus_rdata, pat_lo(5));
        acc(1'b1, 16'hC006, pat_lo(6), 1'b1, 1'b1, pat_lo(5), "R6");

        // R7: misses neither hit nor modify anything, and read zero
        acc(1'b1, 16'hC100, 8'h77, 1'b0, 1'b0, 8'h00, "R7");
        acc(1'b1, 16'hD100, 8'h77, 1'b0, 1'b0, 8'h00, "R7");
        acc(1'b1, 16'hBFFF, 8'h77, 1'b0, 1'b0, 8'h00, "R7");
        acc(1'b1, 16'hE000, 8'h77, 1'b0, 1'b0, 8'h00, "R7");
        acc(1'b1, 16'hFF71, 8'h77, 1'b0, 1'b0, 8'h00, "R7");
        acc(1'b1, 16'hFF6F, 8'h77, 1'b0, 1'b0, 8'h00, "R7");
        acc(1'b0, 16'hC0FF, 8'h00, 1'b1, 1'b1, pat_lo(255), "R7");
        acc(1'b0, 16'hC100, 8'h00, 1'b0, 1'b1, 8'h00, "R7");
        acc(1'b0, 16'hD0FF, 8'h00, 1'b1, 1'b1, pat_hi(3, 255), "R7");
        acc(1'b0, 16'hE000, 8'h00, 1'b0, 1'b1, 8'h00, "R7");
        acc(1'b0, 16'hC000, 8'h00, 1'b1, 1'b1, pat_lo(0), "R7");
        acc(1'b0, 16'hFF71, 8'h00, 1'b0, 1'b1, 8'h00, "R7");
        acc(1'b0, 16'hFF70, 8'h00, 1'b1, 1'b1, 8'h03, "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule